// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Collision Arbiter

This block is a 2048-word by 8-bit storage array that two masters, called left and right, reach through two independent ports. Each port carries its own address, write data, read data and three active-low controls: select, a read/write strobe that requests a write when low, and an output enable that gates returned read data. Both ports are sampled on one common clock, so either side may read or write any word in any cycle.

A collision arbiter compares the two ports every cycle. When both are selected on the same address it grants one of them and pulls the active-low busy flag of the other. The grant goes to the side that was already selected at that address on the previous clock. When both arrive in the same clock the right side is flagged. The grant stays with the winner for as long as the match lasts. The decision depends only on select and address, never on the access direction. A write from the flagged side is dropped inside the block, so the loser cannot corrupt the word the winner is using.

Read data is registered, so it appears one clock after the request, together with a data-valid flag.

Top module: `dpram_arb`

## Requirements
- R1: A write on a port (select low, read/write low) stores the data; a read of that address (select low, read/write high, output enable low) on the same port one or more clocks later returns it on the read-data bus one clock after the read is issued, with the data-valid flag high.
- R2: Writes from both ports in the same clock to different addresses are both stored.
- R3: With select high a port neither writes nor reads: the stored word is unchanged and the data-valid flag stays low with read data zero on the next clock.
- R4: A read issued with output enable high produces data-valid low and read data zero on the next clock.
- R5: Busy is low on a side only when both selects are low and the addresses are equal; in that case exactly one busy flag is low, and otherwise both stay high.
- R6: The two busy flags are never low in the same cycle.
- R7: Arbitration ignores the read/write strobe: two simultaneous reads collide exactly as two writes or a read and a write do.
- R8: A port that was selected on the same address in the previous clock beats a port that has just arrived there, and it keeps the grant while both stay selected on that address.
- R9: When both ports reach the same address in the same clock, the right busy flag goes low.
- R10: A write requested by a port whose busy flag is low leaves memory unchanged.
- R11: A word written by one port is returned by a read from the other port issued on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| lf_cs_n | input | 1 | Left select, active low |
| lf_rw_n | input | 1 | Left strobe: low writes, high reads |
| lf_oe_n | input | 1 | Left output enable, active low |
| lf_addr | input | 11 | Left word address |
| lf_wdata | input | 8 | Left write data |
| lf_rdata | output | 8 | Left read data, zero when not valid |
| lf_rd_vld | output | 1 | Left read data valid |
| lf_busy_n | output | 1 | Left busy flag, low when left lost arbitration |
| rt_cs_n | input | 1 | Right select, active low |
| rt_rw_n | input | 1 | Right strobe: low writes, high reads |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | 11 | Right word address |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right read data, zero when not valid |
| rt_rd_vld | output | 1 | Right read data valid |
| rt_busy_n | output | 1 | Right busy flag, low when right lost arbitration |

## Verification
The functions that can meet in one cycle are the two ports' accesses to a single word, where the arbiter must pick a winner and suppress the loser's write before the clock edge commits it. The bench provokes this by driving both ports onto one address in the same clock (two writes, two reads, and a read against a write) and by staggering them, with one side parked on the address a clock ahead or moving onto the other's address. The busy flags are judged combinationally before the edge, and the outcome is judged afterwards by reading the word back, which must still hold the winner's data or the earlier value.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;

    // Which port currently holds the grant on a colliding address
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpram_arb_arbiter.sv
module dpram_arb_arbiter
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy_n,
    output logic              r_busy_n
);

    typedef struct packed {
        owner_e            owner;
        logic              l_act;
        logic [ADDR_W-1:0] l_addr;
        logic              r_act;
        logic [ADDR_W-1:0] r_addr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       match;
    logic       l_settled;
    logic       r_settled;
    owner_e     winner;

    always_comb begin
        st_d      = st_q;
        match     = !l_cs_n && !r_cs_n && (l_addr == r_addr);
        // a port has settled when it was selected on this address last clock
        l_settled = st_q.l_act && (st_q.l_addr == l_addr);
        r_settled = st_q.r_act && (st_q.r_addr == r_addr);
        winner    = OWN_LEFT;
        if (st_q.owner == OWN_RIGHT) begin
            winner = OWN_RIGHT;
        end else if (st_q.owner == OWN_LEFT) begin
            winner = OWN_LEFT;
        end else if (r_settled && !l_settled) begin
            winner = OWN_RIGHT;
        end else begin
            winner = OWN_LEFT;   // left settled first, or a tie
        end
        st_d.owner  = match ? winner : OWN_NONE;
        st_d.l_act  = !l_cs_n;
        st_d.l_addr = l_addr;
        st_d.r_act  = !r_cs_n;
        st_d.r_addr = r_addr;
        l_busy_n    = !(match && (winner == OWN_RIGHT));
        r_busy_n    = !(match && (winner == OWN_LEFT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, l_act: 1'b0, l_addr: '0,
                      r_act: 1'b0, r_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpram_arb_port.sv
module dpram_arb_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] mem_q,
    output logic              wr_en,
    output logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld
);

    typedef struct packed {
        logic drive;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        wr_en      = !cs_n && !rw_n && busy_n;
        rd_en      = !cs_n && rw_n;
        st_d.drive = rd_en && !oe_n;
        rd_vld     = st_q.drive;
        rdata      = st_q.drive ? mem_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{drive: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpram_arb_store.sv
module dpram_arb_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_a,
    input  logic              rd_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] q_a,
    input  logic              wr_b,
    input  logic              rd_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] q_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q_a_q, q_b_q;

    always_ff @(posedge clk) begin
        if (wr_b) mem[addr_b] <= wdata_b;
        if (wr_a) mem[addr_a] <= wdata_a;
        if (rd_a) q_a_q <= mem[addr_a];
        if (rd_b) q_b_q <= mem[addr_b];
    end

    assign q_a = q_a_q;
    assign q_b = q_b_q;

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lf_cs_n,
    input  logic              lf_rw_n,
    input  logic              lf_oe_n,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic [DATA_W-1:0] lf_wdata,
    output logic [DATA_W-1:0] lf_rdata,
    output logic              lf_rd_vld,
    output logic              lf_busy_n,
    input  logic              rt_cs_n,
    input  logic              rt_rw_n,
    input  logic              rt_oe_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_rd_vld,
    output logic              rt_busy_n
);

    logic              lf_wr_en, lf_rd_en, rt_wr_en, rt_rd_en;
    logic [DATA_W-1:0] lf_mem_q, rt_mem_q;

    dpram_arb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_cs_n   (lf_cs_n),
        .l_addr   (lf_addr),
        .r_cs_n   (rt_cs_n),
        .r_addr   (rt_addr),
        .l_busy_n (lf_busy_n),
        .r_busy_n (rt_busy_n)
    );

    dpram_arb_port #(.DATA_W(DATA_W)) u_lf (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (lf_cs_n),
        .rw_n   (lf_rw_n),
        .oe_n   (lf_oe_n),
        .busy_n (lf_busy_n),
        .mem_q  (lf_mem_q),
        .wr_en  (lf_wr_en),
        .rd_en  (lf_rd_en),
        .rdata  (lf_rdata),
        .rd_vld (lf_rd_vld)
    );

    dpram_arb_port #(.DATA_W(DATA_W)) u_rt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (rt_cs_n),
        .rw_n   (rt_rw_n),
        .oe_n   (rt_oe_n),
        .busy_n (rt_busy_n),
        .mem_q  (rt_mem_q),
        .wr_en  (rt_wr_en),
        .rd_en  (rt_rd_en),
        .rdata  (rt_rdata),
        .rd_vld (rt_rd_vld)
    );

    dpram_arb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_a    (lf_wr_en),
        .rd_a    (lf_rd_en),
        .addr_a  (lf_addr),
        .wdata_a (lf_wdata),
        .q_a     (lf_mem_q),
        .wr_b    (rt_wr_en),
        .rd_b    (rt_rd_en),
        .addr_b  (rt_addr),
        .wdata_b (rt_wdata),
        .q_b     (rt_mem_q)
    );

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lf_cs_n,
    input logic              rt_cs_n,
    input logic [ADDR_W-1:0] lf_addr,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              lf_busy_n,
    input logic              rt_busy_n,
    input logic              lf_wr,
    input logic              rt_wr
);

    logic same;
    assign same = !lf_cs_n && !rt_cs_n && (lf_addr == rt_addr);

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lf_busy_n && !rt_busy_n)); // R6
    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!lf_busy_n || !rt_busy_n) |-> same); // R5
    AST_MATCH_FLAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        same |-> (lf_busy_n != rt_busy_n)); // R5
    AST_HOLD_LEFT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !rt_busy_n) |=> (!same || !rt_busy_n)); // R8
    AST_HOLD_RIGHT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !lf_busy_n) |=> (!same || !lf_busy_n)); // R8
    AST_TIE_FLAGS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (same && $past(lf_cs_n) && $past(rt_cs_n)) |-> !rt_busy_n); // R9
    AST_LEFT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_busy_n |-> !lf_wr); // R10
    AST_RIGHT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_busy_n |-> !rt_wr); // R10

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lf_cs_n   (lf_cs_n),
    .rt_cs_n   (rt_cs_n),
    .lf_addr   (lf_addr),
    .rt_addr   (rt_addr),
    .lf_busy_n (lf_busy_n),
    .rt_busy_n (rt_busy_n),
    .lf_wr     (lf_wr_en),
    .rt_wr     (rt_wr_en)
);

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lf_cs_n = 1'b1, lf_rw_n = 1'b1, lf_oe_n = 1'b1;
    logic [10:0] lf_addr = '0;
    logic [7:0]  lf_wdata = '0;
    logic        rt_cs_n = 1'b1, rt_rw_n = 1'b1, rt_oe_n = 1'b1;
    logic [10:0] rt_addr = '0;
    logic [7:0]  rt_wdata = '0;
    logic [7:0]  lf_rdata, rt_rdata;
    logic        lf_rd_vld, rt_rd_vld, lf_busy_n, rt_busy_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dpram_arb dut (
        .clk(clk), .rst_n(rst_n),
        .lf_cs_n(lf_cs_n), .lf_rw_n(lf_rw_n), .lf_oe_n(lf_oe_n),
        .lf_addr(lf_addr), .lf_wdata(lf_wdata), .lf_rdata(lf_rdata),
        .lf_rd_vld(lf_rd_vld), .lf_busy_n(lf_busy_n),
        .rt_cs_n(rt_cs_n), .rt_rw_n(rt_rw_n), .rt_oe_n(rt_oe_n),
        .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata),
        .rt_rd_vld(rt_rd_vld), .rt_busy_n(rt_busy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_l(input logic cs, input logic rw, input logic oe,
                           input logic [10:0] a, input logic [7:0] d);
        lf_cs_n = cs; lf_rw_n = rw; lf_oe_n = oe; lf_addr = a; lf_wdata = d;
    endtask

    task automatic drive_r(input logic cs, input logic rw, input logic oe,
                           input logic [10:0] a, input logic [7:0] d);
        rt_cs_n = cs; rt_rw_n = rw; rt_oe_n = oe; rt_addr = a; rt_wdata = d;
    endtask

    task automatic idle();
        drive_l(1'b1, 1'b1, 1'b1, '0, '0);
        drive_r(1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic wr_l(input logic [10:0] a, input logic [7:0] d);
        drive_l(1'b0, 1'b0, 1'b1, a, d);
        tick();
        idle();
    endtask

    task automatic rd_l(input logic [10:0] a, output logic [7:0] d);
        drive_l(1'b0, 1'b1, 1'b0, a, '0);
        tick();
        d = lf_rdata;
        idle();
    endtask

    task automatic rd_r(input logic [10:0] a, output logic [7:0] d);
        drive_r(1'b0, 1'b1, 1'b0, a, '0);
        tick();
        d = rt_rdata;
        idle();
    endtask

    task automatic t_reset();
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R5 reset left busy", lf_busy_n, 1);
        check("R5 reset right busy", rt_busy_n, 1);
        check("R4 reset left valid", lf_rd_vld, 0);
        check("R4 reset right data", rt_rdata, 0);
    endtask

    task automatic t_distinct();
        logic [7:0] d;
        drive_l(1'b0, 1'b0, 1'b1, 11'h010, 8'h5A);
        drive_r(1'b0, 1'b0, 1'b1, 11'h020, 8'hC3);
        #1;
        check("R5 distinct addr left busy", lf_busy_n, 1);
        check("R5 distinct addr right busy", rt_busy_n, 1);
        tick();
        idle();
        rd_l(11'h010, d);
        check("R1 left readback", d, 8'h5A);
        check("R1 left valid", lf_rd_vld, 1);
        rd_l(11'h020, d);
        check("R2 right write seen", d, 8'hC3);
        // R11: right reads the clock after left writes
        drive_l(1'b0, 1'b0, 1'b1, 11'h050, 8'h3C);
        tick();
        idle();
        rd_r(11'h050, d);
        check("R11 cross-port read after write", d, 8'h3C);
    endtask

    task automatic t_deselect();
        logic [7:0] d;
        drive_l(1'b1, 1'b0, 1'b1, 11'h010, 8'hFF);
        tick();
        drive_l(1'b1, 1'b1, 1'b0, 11'h010, 8'h00);
        tick();
        check("R3 deselected read valid", lf_rd_vld, 0);
        check("R3 deselected read data", lf_rdata, 0);
        idle();
        rd_l(11'h010, d);
        check("R3 deselected write ignored", d, 8'h5A);
        // one side deselected on the same address: no busy
        drive_l(1'b0, 1'b1, 1'b0, 11'h070, 8'h00);
        drive_r(1'b1, 1'b1, 1'b0, 11'h070, 8'h00);
        #1;
        check("R5 one deselected left busy", lf_busy_n, 1);
        check("R5 one deselected right busy", rt_busy_n, 1);
        tick();
        idle();
    endtask

    task automatic t_oe();
        drive_l(1'b0, 1'b1, 1'b1, 11'h010, 8'h00);
        tick();
        check("R4 oe high valid", lf_rd_vld, 0);
        check("R4 oe high data", lf_rdata, 0);
        idle();
        tick();
    endtask

    task automatic t_tie_write();
        logic [7:0] d;
        drive_l(1'b0, 1'b0, 1'b1, 11'h030, 8'h11);
        drive_r(1'b0, 1'b0, 1'b1, 11'h030, 8'h22);
        #1;
        check("R9 tie left busy", lf_busy_n, 1);
        check("R9 tie right busy", rt_busy_n, 0);
        tick();
        idle();
        rd_l(11'h030, d);
        check("R10 tie loser write dropped", d, 8'h11);
    endtask

    task automatic t_stagger();
        logic [7:0] d;
        wr_l(11'h040, 8'h99);
        drive_r(1'b0, 1'b1, 1'b0, 11'h040, 8'h00);
        tick();
        drive_l(1'b0, 1'b0, 1'b1, 11'h040, 8'h77);
        #1;
        check("R8 late left flagged", lf_busy_n, 0);
        check("R8 early right granted", rt_busy_n, 1);
        tick();
        check("R8 grant held left busy", lf_busy_n, 0);
        check("R8 grant held right busy", rt_busy_n, 1);
        tick();
        idle();
        rd_l(11'h040, d);
        check("R10 late writer blocked", d, 8'h99);
        // right moves onto an address left already holds
        wr_l(11'h060, 8'hAA);
        drive_l(1'b0, 1'b1, 1'b0, 11'h060, 8'h00);
        drive_r(1'b0, 1'b1, 1'b0, 11'h061, 8'h00);
        tick();
        drive_r(1'b0, 1'b0, 1'b1, 11'h060, 8'h55);
        #1;
        check("R8 mover right flagged", rt_busy_n, 0);
        check("R8 holder left granted", lf_busy_n, 1);
        tick();
        idle();
        rd_l(11'h060, d);
        check("R10 mover write blocked", d, 8'hAA);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        drive_l(1'b0, 1'b1, 1'b0, 11'h010, 8'h00);
        drive_r(1'b0, 1'b1, 1'b0, 11'h010, 8'h00);
        #1;
        check("R7 two reads collide right", rt_busy_n, 0);
        check("R7 two reads collide left", lf_busy_n, 1);
        tick();
        idle();
        tick();
        drive_l(1'b0, 1'b1, 1'b0, 11'h010, 8'h00);
        drive_r(1'b0, 1'b0, 1'b1, 11'h010, 8'hEE);
        #1;
        check("R7 read vs write right flagged", rt_busy_n, 0);
        tick();
        idle();
        rd_l(11'h010, d);
        check("R10 flagged writer vs reader", d, 8'h5A);
    endtask

    initial begin
        t_reset();
        t_distinct();
        t_deselect();
        t_oe();
        t_tie_write();
        t_stagger();
        t_direction();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule